// File: doc/BRIEF.md
# Vector iota and index generator

This block computes one destination vector register for either of two vector integer operations. The iota operation writes each element with the number of earlier active elements whose source mask bit is set. The count excludes the element's own bit. The index operation writes each active element with its own element number. The block receives the instruction word together with the vector configuration (element width code, vector length, start index, illegal-configuration flag) and full copies of the source mask register, the v0 mask register, the source vector register and the old destination contents. It captures these on `start_i` and returns the finished register on `vd_o`.

Work proceeds one element per clock. A word that does not decode as one of the two operations is rejected with a one-cycle illegal flag, and so is an unusable configuration. A rejected word leaves the destination untouched. The register width is a parameter. The grouping factor is fixed at one, so the mask bit for element i sits at the same bit offset as the element's low bit.

Top module: `vec_iota_idx`

## Requirements
- R1: A word is recognised only when bits 6:0 are 0x57, bits 14:12 are 2 and bits 31:26 are 6'b010110. Bits 19:15 then select the operation: 16 selects iota and 17 selects index. Bit 25 is the unmasked flag (vm). Any other word is rejected.
- R2: A word is rejected when it is unrecognised, when vstart is non-zero, when the illegal-configuration flag is set, or when the width code is above 3. On rejection `illegal_o` pulses for exactly the one cycle after the accepting edge. `done_o` and `busy_o` stay low and `vd_o` is unchanged.
- R3: For iota, an active element i receives the count of active elements below i whose source mask bit is 1. An element is active when vm=1 or its v0 bit is 1.
- R4: For iota, an inactive element receives the source vector element at the same index, and it adds nothing to the count.
- R5: For index, an active element i receives i. An inactive element keeps its old destination value.
- R6: Iota writes elements 0 to VLMAX-1. Index writes elements 0 to min(vl,VLMAX)-1. VLMAX is VLEN/SEW. Elements outside the range keep the old destination value.
- R7: Width code 0, 1, 2 and 3 selects SEW of 8, 16, 32 and 64 bits. Element i occupies bits [SEW*i +: SEW], and values are truncated to SEW bits.
- R8: One element is written per clock. `done_o` pulses for one cycle, first seen n edges after the accepting edge, where n is the element count of R6 (0 for an empty index run).
- R9: `busy_o` is high from the accepting edge until `done_o` ends. A `start_i` seen while busy is ignored. All operand inputs are captured at the accepting edge, so later changes to them have no effect.
- R10: Mask and v0 bits at offsets other than SEW*i are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted when idle |
| instr_i | input | 32 | Instruction word |
| vsew_i | input | 3 | Element width code |
| vl_i | input | VL_W | Vector length |
| vstart_i | input | VL_W | Start index; must be zero |
| vill_i | input | 1 | Illegal vector configuration flag |
| mask_src_i | input | VLEN | Source mask register |
| v0_i | input | VLEN | v0 mask register |
| vsrc_i | input | VLEN | Source vector register (iota inactive copy) |
| vd_init_i | input | VLEN | Old destination contents |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | One-cycle rejection pulse |
| vd_o | output | VLEN | Destination register |

## Verification
The hardest case is an iota run in which inactive elements fall between set mask bits. Here the count must skip those elements, and their source vector values must show through. The mask and v0 registers also carry noise at every bit position that is not an element offset. The stimulus covers this with a sweep over all four widths, both vm values and several pseudo-random and structured mask patterns. The index operation is swept over every vl from 0 to VLMAX+1. A separate run pulses `start_i` with a bad word and inverts every operand bus while a run is in flight.

// File: rtl/viota_pkg.sv
package viota_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
  typedef enum logic {OP_IOTA, OP_INDEX} op_e;

  localparam logic [6:0] OPC_VEC   = 7'h57;
  localparam logic [2:0] F3_MVV    = 3'b010;
  localparam logic [5:0] F6_MUNARY = 6'b010110;
  localparam logic [4:0] SEL_IOTA  = 5'd16;
  localparam logic [4:0] SEL_INDEX = 5'd17;

  typedef struct packed {
    logic hit;
    logic legal;
    op_e  op;
    logic vm;
  } dec_t;
endpackage

// File: rtl/viota_decode.sv
module viota_decode
  import viota_pkg::*;
#(
  parameter int VL_W = 5
) (
  input  logic [31:0]     instr_i,
  input  logic [2:0]      vsew_i,
  input  logic [VL_W-1:0] vstart_i,
  input  logic            vill_i,
  output dec_t            dec_o
);
  logic [4:0] sel;
  logic       fmt_ok;

  assign sel    = instr_i[19:15];
  assign fmt_ok = (instr_i[6:0] == OPC_VEC) && (instr_i[14:12] == F3_MVV) &&
                  (instr_i[31:26] == F6_MUNARY);

  always_comb begin
    dec_o.hit   = fmt_ok && ((sel == SEL_IOTA) || (sel == SEL_INDEX));
    dec_o.op    = (sel == SEL_INDEX) ? OP_INDEX : OP_IOTA;
    dec_o.vm    = instr_i[25];
    dec_o.legal = dec_o.hit && (vstart_i == '0) && !vill_i && (vsew_i <= 3'd3);
  end
endmodule

// File: rtl/viota_seq.sv
module viota_seq
  import viota_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int IDX_W = 4,
  parameter int VL_W  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             legal_i,
  input  op_e              op_i,
  input  logic [1:0]       sew_i,
  input  logic [VL_W-1:0]  vl_i,
  output logic             accept_o,
  output logic             step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             illegal_o
);
  st_e             st_q, st_d;
  logic [VL_W-1:0] n_q, n_calc, vlmax;
  logic [IDX_W-1:0] idx_q;
  logic            last;

  assign vlmax    = VL_W'(VLEN >> (3 + sew_i));
  assign n_calc   = (op_i == OP_IOTA) ? vlmax : ((vl_i < vlmax) ? vl_i : vlmax);
  assign accept_o = start_i && (st_q == ST_IDLE) && legal_i;
  assign step_o   = (st_q == ST_RUN);
  assign last     = (VL_W'(idx_q) + VL_W'(1)) == n_q;
  assign idx_o    = idx_q;
  assign busy_o   = (st_q != ST_IDLE);
  assign done_o   = (st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept_o) st_d = (n_calc == '0) ? ST_DONE : ST_RUN;
      ST_RUN:  if (last) st_d = ST_DONE;
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      n_q       <= '0;
      idx_q     <= '0;
      illegal_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      illegal_o <= start_i && (st_q == ST_IDLE) && !legal_i;
      if (accept_o) begin
        n_q   <= n_calc;
        idx_q <= '0;
      end else if (step_o && !last) begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/viota_lane.sv
module viota_lane
  import viota_pkg::*;
#(
  parameter int VLEN  = 128,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic [1:0]       sew_i,
  input  op_e              op_i,
  input  logic             vm_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [VLEN-1:0]  mask_i,
  input  logic [VLEN-1:0]  v0_i,
  input  logic [VLEN-1:0]  vsrc_i,
  output logic             wr_en_o,
  output logic [63:0]      wr_val_o,
  output logic             cnt_inc_o
);
  localparam int OFF_W = $clog2(VLEN);

  logic [3:0]  mbit, vbit;
  logic [63:0] elem [4];

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int W  = 8 << g;
    localparam int NE = VLEN / W;
    logic [IDX_W-1:0] li;
    logic [OFF_W-1:0] off;
    assign li      = idx_i & IDX_W'(NE - 1);
    assign off     = OFF_W'(li) << (3 + g);
    assign mbit[g] = mask_i[off];
    assign vbit[g] = v0_i[off];
    assign elem[g] = 64'(vsrc_i[off +: W]);
  end

  logic active, mb;
  assign active = vm_i || vbit[sew_i];
  assign mb     = mbit[sew_i];

  always_comb begin
    if (op_i == OP_IOTA) begin
      wr_en_o   = 1'b1;
      wr_val_o  = active ? 64'(cnt_i) : elem[sew_i];
      cnt_inc_o = active && mb;
    end else begin
      wr_en_o   = active;
      wr_val_o  = 64'(idx_i);
      cnt_inc_o = 1'b0;
    end
  end
endmodule

// File: rtl/vec_iota_idx.sv
module vec_iota_idx
  import viota_pkg::*;
#(
  parameter int VLEN  = 128,
  localparam int IDX_W = $clog2(VLEN / 8),
  localparam int VL_W  = IDX_W + 1,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [31:0]     instr_i,
  input  logic [2:0]      vsew_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [VL_W-1:0] vstart_i,
  input  logic            vill_i,
  input  logic [VLEN-1:0] mask_src_i,
  input  logic [VLEN-1:0] v0_i,
  input  logic [VLEN-1:0] vsrc_i,
  input  logic [VLEN-1:0] vd_init_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            illegal_o,
  output logic [VLEN-1:0] vd_o
);
  localparam int OFF_W = $clog2(VLEN);

  dec_t             dec;
  logic             accept, step, wr_en, cnt_inc;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] cnt_q;
  logic [63:0]      wr_val;
  op_e              op_q;
  logic             vm_q;
  logic [1:0]       sew_q;
  logic [VLEN-1:0]  mask_q, v0_q, vsrc_q, vd_q;

  viota_decode #(.VL_W(VL_W)) u_dec (
    .instr_i (instr_i),
    .vsew_i  (vsew_i),
    .vstart_i(vstart_i),
    .vill_i  (vill_i),
    .dec_o   (dec)
  );

  viota_seq #(.VLEN(VLEN), .IDX_W(IDX_W), .VL_W(VL_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .legal_i  (dec.legal),
    .op_i     (dec.op),
    .sew_i    (vsew_i[1:0]),
    .vl_i     (vl_i),
    .accept_o (accept),
    .step_o   (step),
    .idx_o    (idx),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .illegal_o(illegal_o)
  );

  viota_lane #(.VLEN(VLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_lane (
    .sew_i    (sew_q),
    .op_i     (op_q),
    .vm_i     (vm_q),
    .idx_i    (idx),
    .cnt_i    (cnt_q),
    .mask_i   (mask_q),
    .v0_i     (v0_q),
    .vsrc_i   (vsrc_q),
    .wr_en_o  (wr_en),
    .wr_val_o (wr_val),
    .cnt_inc_o(cnt_inc)
  );

  // element write: shifted field mask truncates value to SEW
  logic [6:0]      sew_bits;
  logic [63:0]     ones_w;
  logic [OFF_W-1:0] woff;
  logic [VLEN-1:0] wmask, wdata;

  assign sew_bits = 7'd8 << sew_q;
  assign ones_w   = {64{1'b1}} >> (7'd64 - sew_bits);
  assign woff     = OFF_W'(idx) << (3 + sew_q);
  assign wmask    = VLEN'(ones_w) << woff;
  assign wdata    = VLEN'(wr_val) << woff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IOTA;
      vm_q   <= 1'b0;
      sew_q  <= '0;
      mask_q <= '0;
      v0_q   <= '0;
      vsrc_q <= '0;
      vd_q   <= '0;
      cnt_q  <= '0;
    end else if (accept) begin
      op_q   <= dec.op;
      vm_q   <= dec.vm;
      sew_q  <= vsew_i[1:0];
      mask_q <= mask_src_i;
      v0_q   <= v0_i;
      vsrc_q <= vsrc_i;
      vd_q   <= vd_init_i;
      cnt_q  <= '0;
    end else if (step) begin
      if (wr_en) vd_q <= (vd_q & ~wmask) | (wdata & wmask);
      if (cnt_inc) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign vd_o = vd_q;
endmodule

// File: rtl/viota_checker.sv
module viota_checker #(
  parameter int VLEN  = 128,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             illegal_o,
  input logic [VLEN-1:0]  vd_o,
  input logic             step,
  input logic [IDX_W-1:0] idx,
  input logic [CNT_W-1:0] cnt_q
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_ILLEGAL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> !illegal_o); // R2
  AST_ILLEGAL_KEEPS_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($stable(vd_o) && !busy_o && !done_o)); // R2
  AST_IDLE_DEST_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(vd_o)); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R9
  AST_COUNT_BELOW_INDEX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> (cnt_q <= CNT_W'(idx))); // R3
endmodule

bind vec_iota_idx viota_checker #(.VLEN(VLEN), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .illegal_o(illegal_o),
  .vd_o     (vd_o),
  .step     (step),
  .idx      (idx),
  .cnt_q    (cnt_q)
);

// File: tb/vec_iota_idx_tb.sv
module vec_iota_idx_tb;
  localparam int VLEN = 128;
  localparam int VL_W = $clog2(VLEN / 8) + 1;

  logic clk = 1'b0, rst_ni = 1'b0, start_i = 1'b0, vill_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [2:0] vsew_i = '0;
  logic [VL_W-1:0] vl_i = '0, vstart_i = '0;
  logic [VLEN-1:0] mask_src_i = '0, v0_i = '0, vsrc_i = '0, vd_init_i = '0;
  logic busy_o, done_o, illegal_o;
  logic [VLEN-1:0] vd_o;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5679;

  always #10 clk = ~clk;

  vec_iota_idx #(.VLEN(VLEN)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .instr_i(instr_i),
    .vsew_i(vsew_i), .vl_i(vl_i), .vstart_i(vstart_i), .vill_i(vill_i),
    .mask_src_i(mask_src_i), .v0_i(v0_i), .vsrc_i(vsrc_i), .vd_init_i(vd_init_i),
    .busy_o(busy_o), .done_o(done_o), .illegal_o(illegal_o), .vd_o(vd_o)
  );

  task automatic check(input bit ok, input string req, input logic [VLEN-1:0] act,
                       input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd32();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  function automatic logic [VLEN-1:0] rndv();
    logic [VLEN-1:0] v;
    for (int k = 0; k < VLEN / 32; k++) v[k*32 +: 32] = rnd32();
    return v;
  endfunction

  function automatic logic [31:0] mk(input logic [4:0] sel, input bit vm);
    return {6'b010110, vm, 5'd3, sel, 3'b010, 5'd7, 7'h57};
  endfunction

  function automatic logic [VLEN-1:0] put(input logic [VLEN-1:0] v, input int off,
                                          input int w, input logic [63:0] val);
    for (int b = 0; b < w; b++) v[off + b] = val[b];
    return v;
  endfunction

  function automatic logic [VLEN-1:0] model(input bit is_idx, input int sew, input bit vm,
      input int vl, input logic [VLEN-1:0] m, v0, src, init);
    logic [VLEN-1:0] e = init;
    int w = 8 << sew, ne = VLEN / w, n, cnt = 0;
    n = is_idx ? ((vl < ne) ? vl : ne) : ne;
    for (int i = 0; i < n; i++) begin
      int off = i * w;
      bit act = vm || v0[off];
      if (is_idx) begin
        if (act) e = put(e, off, w, 64'(i));
      end else if (act) begin
        e = put(e, off, w, 64'(cnt));
        if (m[off]) cnt++;
      end else begin
        e = put(e, off, w, 64'(src[off +: 64] & ({64{1'b1}} >> (64 - w))));
      end
    end
    return e;
  endfunction

  task automatic run(input logic [31:0] ins, input logic [2:0] sew, input int vl,
      input int vst, input bit vil, input logic [VLEN-1:0] m, v0, src, init,
      input bit inject, output int lat, output bit gd, output bit gi);
    @(negedge clk);
    instr_i = ins; vsew_i = sew; vl_i = VL_W'(vl); vstart_i = VL_W'(vst);
    vill_i = vil; mask_src_i = m; v0_i = v0; vsrc_i = src; vd_init_i = init;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    if (inject) begin
      mask_src_i = ~m; v0_i = ~v0; vsrc_i = ~src; vd_init_i = ~init;
      instr_i = 32'h0; vsew_i = 3'd3 - sew;
    end
    lat = 0;
    while (!done_o && !illegal_o && lat < 100) begin
      if (inject && lat == 1) start_i = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start_i = 1'b0;
      lat++;
    end
    gd = done_o;
    gi = illegal_o;
  endtask

  task automatic do_op(input bit is_idx, input int sew, input bit vm, input int vl,
      input logic [VLEN-1:0] m, v0, src, init, input bit inject, input string tag);
    int lat, ne, n;
    bit gd, gi;
    logic [VLEN-1:0] exp;
    ne = VLEN / (8 << sew);
    n = is_idx ? ((vl < ne) ? vl : ne) : ne;
    exp = model(is_idx, sew, vm, vl, m, v0, src, init);
    run(mk(is_idx ? 5'd17 : 5'd16, vm), 3'(sew), vl, 0, 1'b0, m, v0, src, init,
        inject, lat, gd, gi);
    check(gd && !gi, {tag, " R8 done"}, VLEN'({gd, gi}), VLEN'(2'b10));
    check(lat == n, {tag, " R8 latency"}, VLEN'(lat), VLEN'(n));
    check(vd_o == exp, tag, vd_o, exp);
    @(posedge clk);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 R9 done pulse ends", VLEN'({done_o, busy_o}), '0);
  endtask

  task automatic bad(input logic [31:0] ins, input logic [2:0] sew, input int vst,
                     input bit vil, input string tag);
    int lat;
    bit gd, gi;
    logic [VLEN-1:0] prev;
    prev = vd_o;
    run(ins, sew, 4, vst, vil, rndv(), rndv(), rndv(), rndv(), 1'b0, lat, gd, gi);
    check(gi && !gd && !busy_o && lat == 0, {tag, " flag"}, VLEN'({gi, gd, busy_o}),
          VLEN'(3'b100));
    check(vd_o == prev, {tag, " dest kept"}, vd_o, prev);
    @(posedge clk);
    @(negedge clk);
    check(!illegal_o, {tag, " pulse ends"}, VLEN'(illegal_o), '0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] m, v0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !done_o && !illegal_o && vd_o == '0, "reset state",
          VLEN'({busy_o, done_o, illegal_o}), '0);
    rst_ni = 1'b1;

    // R3 R4 R7 R10: iota over widths, vm, mask patterns with noise off-offset
    for (int sew = 0; sew < 4; sew++)
      for (int vm = 0; vm < 2; vm++)
        for (int p = 0; p < 5; p++) begin
          case (p)
            0: begin m = '1; v0 = rndv(); end
            1: begin m = {(VLEN/2){2'b01}} ^ {(VLEN/8){8'hF0}}; v0 = ~rndv(); end
            2: begin m = rndv(); v0 = rndv(); end
            3: begin m = rndv(); v0 = '0; end
            default: begin m = '0; v0 = rndv(); end
          endcase
          do_op(1'b0, sew, vm[0], 0, m, v0, rndv(), rndv(), 1'b0, "R3 R4 R7 R10 iota");
        end

    // R5 R6 R7: index across every vl up to VLMAX+1
    for (int sew = 0; sew < 4; sew++)
      for (int vm = 0; vm < 2; vm++)
        for (int vl = 0; vl <= VLEN / (8 << sew) + 1; vl++)
          do_op(1'b1, sew, vm[0], vl, rndv(), rndv(), rndv(), rndv(), 1'b0,
                "R5 R6 R7 index");

    // R9: start while busy and operand changes are ignored
    do_op(1'b0, 0, 1'b0, 0, rndv(), rndv(), rndv(), rndv(), 1'b1, "R9 iota inject");
    do_op(1'b1, 1, 1'b0, 6, rndv(), rndv(), rndv(), rndv(), 1'b1, "R9 index inject");

    // R1 R2: rejected words and configurations
    bad(mk(5'd16, 1'b1), 3'd0, 1, 1'b0, "R2 vstart");
    bad(mk(5'd17, 1'b1), 3'd1, 0, 1'b1, "R2 vill");
    bad(mk(5'd16, 1'b0), 3'd4, 0, 1'b0, "R2 sew code");
    bad(mk(5'd18, 1'b1), 3'd0, 0, 1'b0, "R1 sel 18");
    bad(mk(5'd16, 1'b1) ^ 32'h0000_1000, 3'd0, 0, 1'b0, "R1 funct3");
    bad(mk(5'd17, 1'b1) ^ 32'h0000_0001, 3'd0, 0, 1'b0, "R1 opcode");
    bad(mk(5'd16, 1'b1) ^ 32'h0400_0000, 3'd0, 0, 1'b0, "R1 funct6");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule